// File: doc/BRIEF.md
# External Bus Data-Float Wait Controller

This block sequences accesses on a shared static-memory bus. A slow device keeps driving the data lines for a while after its read strobe ends. The block makes sure that this float period is over before the next access drives the bus. For each chip select it keeps a timing set: setup length, strobe length, hold length, float length and a float mode. When the bus is idle it accepts one request, giving the chip select and the direction. It then plays out the access as a run of phases: inserted waits, setup, strobe and hold.

The number of inserted waits depends on the access just finished and on the one about to start. After a read strobe ends, a float period of the read chip select's programmed length begins. Hold cycles and idle cycles run it down. The mode of the chip select that did the read decides how waits are computed. In plain mode the float must be fully over before the next access begins. In overlapped mode the next access's setup cycles may absorb what remains. In either mode, a write that follows a read always gets at least one turnaround wait.

Timing sets are loaded through a simple write port. An access latches its chip select's set when it is accepted, so a later write to that set only affects later accesses.

Top module: `bus_float_ctrl`

## Requirements
- R1: Writing `cfgWe` stores setup, strobe, hold, float and mode values for chip select `cfgSel`. An access uses the values present when it is accepted, and a write made during the access does not change that access.
- R2: A request is accepted at a clock edge where `reqValid` and `reqReady` are both high, and `reqReady` is high only when idle. From the next cycle the block runs W wait cycles, then S setup cycles, then strobe-field+1 strobe cycles (`rdStrobe` for a read, `wrStrobe` for a write), then H hold cycles, and then returns to idle. Zero-length phases are skipped. During setup, strobe and hold, bit `reqCs` of `csActive` is the only bit set.
- R3: A float period of F cycles, where F is the float value of the read's chip select, starts in the cycle after a read's last strobe cycle, and `floatBusy` is high during it. A write never starts a float period. F = 0 gives no float period.
- R4: Plain mode (mode bit 0 on the chip select that performed the read): W equals the number of float cycles still to run after the acceptance cycle. This makes the float end before the next access's first cycle. Hold and idle cycles count toward the float.
- R5: Overlapped mode (mode bit 1 on the reading chip select): W = max(0, remaining float cycles − S of the next access). The mode comes from the chip select that performed the read, not from the next one.
- R6: When the previously accepted access was a read and the new one is a write, W is at least 1, however long the bus was idle.
- R7: A request accepted after the float period has expired, with no turnaround owed, gets W = 0.
- R8: After reset the block is idle with `reqReady` high, all phase outputs low, `csActive` zero, `floatBusy` low and all timing sets zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Timing set write strobe |
| cfgSel | input | 2 | Chip select whose set is written |
| cfgSetup | input | 4 | Setup cycles |
| cfgPulse | input | 4 | Strobe cycles minus one |
| cfgHold | input | 4 | Hold cycles |
| cfgFloat | input | 4 | Float cycles after a read |
| cfgOpt | input | 1 | 1 = overlapped float mode, 0 = plain |
| reqValid | input | 1 | Access request pending |
| reqCs | input | 2 | Requested chip select |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqReady | output | 1 | Idle; a pending request is accepted this edge |
| waitState | output | 1 | Inserted wait cycle |
| setupPhase | output | 1 | Setup cycle |
| rdStrobe | output | 1 | Read strobe active |
| wrStrobe | output | 1 | Write strobe active |
| holdPhase | output | 1 | Hold cycle |
| csActive | output | 4 | One-hot chip select during setup, strobe and hold |
| floatBusy | output | 1 | Read float period running |

## Verification
The main function is exercised with back-to-back access pairs in every combination that changes the wait count. These are read then read and read then write, on the same chip select and on different ones. Each pair is run under both float modes, with a non-zero and a zero next setup, and with a zero-hold chip select. This separates plain from overlapped accounting, shows which chip select supplies the mode, and shows how the turnaround combines with float waits. Pairs split by long idle gaps show expiry and the lasting turnaround. A timing set rewritten during an access shows when new values take effect. A per-cycle reference model checks every phase output against timelines computed from absolute cycle numbers.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  parameter int TIME_W = 4;

  typedef struct packed {
    logic [TIME_W-1:0] setup;
    logic [TIME_W-1:0] pulse;
    logic [TIME_W-1:0] hold;
    logic [TIME_W-1:0] flt;
    logic              opt;
  } timing_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WAIT, PH_SETUP, PH_PULSE, PH_HOLD
  } phase_e;

  typedef struct packed {
    logic   accept;
    logic   load;
    phase_e loadPhase;
    logic   pulseDone;
  } ctl_t;
endpackage

// File: rtl/bfc_datapath.sv
module bfc_datapath
  import bfc_pkg::*;
#(
  parameter int N_CS = 4,
  localparam int CS_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CS_W-1:0]   cfgSel,
  input  timing_t           cfgIn,
  input  logic [CS_W-1:0]   reqCs,
  input  logic              reqWrite,
  input  ctl_t              ctl,
  output logic [TIME_W-1:0] waitNeed,
  output logic [TIME_W-1:0] setupLen,
  output logic [TIME_W-1:0] holdLen,
  output logic              cntZero,
  output logic [CS_W-1:0]   accCs,
  output logic              accWrite,
  output logic              floatBusy
);
  timing_t           cfgArr [N_CS];
  timing_t           acc;
  timing_t           sel;
  timing_t           eff;
  logic [TIME_W-1:0] cnt;
  logic [TIME_W-1:0] floatLeft;
  logic              floatOpt;
  logic              lastRead;
  logic [TIME_W-1:0] remAfter;
  logic [TIME_W-1:0] fltWait;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_CS; i++) cfgArr[i] <= '0;
    end else if (cfgWe) begin
      cfgArr[cfgSel] <= cfgIn;
    end
  end

  always_comb begin
    sel      = cfgArr[reqCs];
    eff      = ctl.accept ? sel : acc;
    remAfter = (floatLeft > TIME_W'(1)) ? floatLeft - TIME_W'(1) : '0;
    if (floatOpt)
      fltWait = (remAfter > sel.setup) ? remAfter - sel.setup : '0;
    else
      fltWait = remAfter;
    waitNeed = (lastRead && reqWrite && fltWait == '0) ? TIME_W'(1) : fltWait;
    setupLen = eff.setup;
    holdLen  = eff.hold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      accCs    <= '0;
      accWrite <= 1'b0;
      lastRead <= 1'b0;
    end else if (ctl.accept) begin
      acc      <= sel;
      accCs    <= reqCs;
      accWrite <= reqWrite;
      lastRead <= !reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      case (ctl.loadPhase)
        PH_WAIT:  cnt <= waitNeed - TIME_W'(1);
        PH_SETUP: cnt <= eff.setup - TIME_W'(1);
        PH_PULSE: cnt <= eff.pulse;
        PH_HOLD:  cnt <= eff.hold - TIME_W'(1);
        default:  cnt <= '0;
      endcase
    end else if (cnt != '0) begin
      cnt <= cnt - TIME_W'(1);
    end
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      floatLeft <= '0;
      floatOpt  <= 1'b0;
    end else if (ctl.pulseDone && !accWrite) begin
      floatLeft <= acc.flt;
      floatOpt  <= acc.opt;
    end else if (floatLeft != '0) begin
      floatLeft <= floatLeft - TIME_W'(1);
    end
  end

  assign floatBusy = (floatLeft != '0);

  AST_PLAIN_CLEAR_IN_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.loadPhase == PH_SETUP && ctl.load) && !floatOpt) |-> !floatBusy); // R4
endmodule

// File: rtl/bfc_control.sv
module bfc_control
  import bfc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [TIME_W-1:0] waitNeed,
  input  logic [TIME_W-1:0] setupLen,
  input  logic [TIME_W-1:0] holdLen,
  input  logic              cntZero,
  output ctl_t              ctl,
  output phase_e            phase
);
  phase_e state;
  phase_e nextPh;

  always_comb begin
    ctl       = '0;
    nextPh    = state;
    case (state)
      PH_IDLE: if (reqValid) begin
        ctl.accept = 1'b1;
        if (waitNeed != '0)      nextPh = PH_WAIT;
        else if (setupLen != '0) nextPh = PH_SETUP;
        else                     nextPh = PH_PULSE;
      end
      PH_WAIT: if (cntZero) nextPh = (setupLen != '0) ? PH_SETUP : PH_PULSE;
      PH_SETUP: if (cntZero) nextPh = PH_PULSE;
      PH_PULSE: if (cntZero) begin
        ctl.pulseDone = 1'b1;
        nextPh = (holdLen != '0) ? PH_HOLD : PH_IDLE;
      end
      PH_HOLD: if (cntZero) nextPh = PH_IDLE;
      default: nextPh = PH_IDLE;
    endcase
    ctl.load      = (nextPh != state);
    ctl.loadPhase = nextPh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextPh;
  end

  assign phase = state;

  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE && reqValid) |=> (state != PH_IDLE)); // R2
endmodule

// File: rtl/bus_float_ctrl.sv
module bus_float_ctrl
  import bfc_pkg::*;
#(
  parameter int N_CS = 4,
  localparam int CS_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CS_W-1:0]   cfgSel,
  input  logic [TIME_W-1:0] cfgSetup,
  input  logic [TIME_W-1:0] cfgPulse,
  input  logic [TIME_W-1:0] cfgHold,
  input  logic [TIME_W-1:0] cfgFloat,
  input  logic              cfgOpt,
  input  logic              reqValid,
  input  logic [CS_W-1:0]   reqCs,
  input  logic              reqWrite,
  output logic              reqReady,
  output logic              waitState,
  output logic              setupPhase,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic              holdPhase,
  output logic [N_CS-1:0]   csActive,
  output logic              floatBusy
);
  timing_t           cfgIn;
  ctl_t              ctl;
  phase_e            phase;
  logic [TIME_W-1:0] waitNeed;
  logic [TIME_W-1:0] setupLen;
  logic [TIME_W-1:0] holdLen;
  logic              cntZero;
  logic [CS_W-1:0]   accCs;
  logic              accWrite;

  always_comb begin
    cfgIn.setup = cfgSetup;
    cfgIn.pulse = cfgPulse;
    cfgIn.hold  = cfgHold;
    cfgIn.flt   = cfgFloat;
    cfgIn.opt   = cfgOpt;
  end

  bfc_datapath #(.N_CS(N_CS)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIn(cfgIn),
    .reqCs(reqCs), .reqWrite(reqWrite), .ctl(ctl), .waitNeed(waitNeed),
    .setupLen(setupLen), .holdLen(holdLen), .cntZero(cntZero),
    .accCs(accCs), .accWrite(accWrite), .floatBusy(floatBusy)
  );

  bfc_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .waitNeed(waitNeed),
    .setupLen(setupLen), .holdLen(holdLen), .cntZero(cntZero),
    .ctl(ctl), .phase(phase)
  );

  always_comb begin
    reqReady   = (phase == PH_IDLE);
    waitState  = (phase == PH_WAIT);
    setupPhase = (phase == PH_SETUP);
    rdStrobe   = (phase == PH_PULSE) && !accWrite;
    wrStrobe   = (phase == PH_PULSE) && accWrite;
    holdPhase  = (phase == PH_HOLD);
    csActive   = '0;
    if (setupPhase || rdStrobe || wrStrobe || holdPhase) csActive[accCs] = 1'b1;
  end

  AST_STROBE_FLOAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe || wrStrobe) |-> !floatBusy); // R4, R5
  AST_WRITE_NO_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrStrobe) |-> !floatBusy); // R3
  AST_WAIT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitState) |-> $past(reqValid && reqReady)); // R2
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({waitState, setupPhase, rdStrobe, wrStrobe, holdPhase})); // R2
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (setupPhase || rdStrobe || wrStrobe || holdPhase) |-> ($countones(csActive) == 1)); // R2
endmodule

// File: tb/bus_float_ctrl_bench.sv
`timescale 1ns/1ps
module bus_float_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [3:0] cfgSetup = '0, cfgPulse = '0, cfgHold = '0, cfgFloat = '0;
  logic cfgOpt = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqCs = '0;
  logic reqWrite = 1'b0;
  logic reqReady, waitState, setupPhase, rdStrobe, wrStrobe, holdPhase, floatBusy;
  logic [3:0] csActive;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_float_ctrl u_bus_float_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgSetup(cfgSetup),
    .cfgPulse(cfgPulse), .cfgHold(cfgHold), .cfgFloat(cfgFloat), .cfgOpt(cfgOpt),
    .reqValid(reqValid), .reqCs(reqCs), .reqWrite(reqWrite), .reqReady(reqReady),
    .waitState(waitState), .setupPhase(setupPhase), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .holdPhase(holdPhase), .csActive(csActive), .floatBusy(floatBusy)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: a queue of per-cycle phase codes plus absolute float timing.
  // codes: 1 wait, 2 setup, 3 read strobe, 13 last read strobe, 4 write strobe, 5 hold
  int q[$];
  int cS[4], cP[4], cH[4], cF[4];
  bit cO[4];
  int cyc = 0, mCs = 0, pulseEnd = -1000, fltF = 0, pendF = 0;
  bit fltOpt = 0, pendOpt = 0, mLastRead = 0;
  int code, t, rem, w;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      for (int i = 0; i < 4; i++) begin cS[i] = 0; cP[i] = 0; cH[i] = 0; cF[i] = 0; cO[i] = 0; end
      cyc = 0; pulseEnd = -1000; fltF = 0; fltOpt = 0; mLastRead = 0; mCs = 0;
    end else begin
      t = cyc;
      if (q.size() > 0) begin
        code = q.pop_front();
        if (code == 13) begin pulseEnd = t; fltF = pendF; fltOpt = pendOpt; end
      end else if (reqValid) begin
        rem = pulseEnd + fltF - t;
        if (rem < 0) rem = 0;
        w = fltOpt ? rem - cS[reqCs] : rem;
        if (w < 0) w = 0;
        if (mLastRead && reqWrite && w < 1) w = 1;
        for (int i = 0; i < w; i++) q.push_back(1);
        for (int i = 0; i < cS[reqCs]; i++) q.push_back(2);
        for (int i = 0; i <= cP[reqCs]; i++)
          q.push_back(reqWrite ? 4 : ((i == cP[reqCs]) ? 13 : 3));
        for (int i = 0; i < cH[reqCs]; i++) q.push_back(5);
        mCs = reqCs; mLastRead = !reqWrite;
        pendF = cF[reqCs]; pendOpt = cO[reqCs];
      end
      if (cfgWe) begin
        cS[cfgSel] = cfgSetup; cP[cfgSel] = cfgPulse; cH[cfgSel] = cfgHold;
        cF[cfgSel] = cfgFloat; cO[cfgSel] = cfgOpt;
      end
      cyc = t + 1;
    end
  end

  initial forever begin
    int f, expV, actV;
    @(posedge clk);
    #1;
    if (rstN && !done) begin
      f = (q.size() > 0) ? q[0] : 0;
      expV = {(q.size() == 0), f == 1, f == 2, (f == 3 || f == 13), f == 4, f == 5,
              (cyc > pulseEnd && cyc <= pulseEnd + fltF)} << 4;
      if (f >= 2) expV = expV | (1 << mCs);
      actV = {reqReady, waitState, setupPhase, rdStrobe, wrStrobe, holdPhase, floatBusy} << 4;
      actV = actV | csActive;
      chk("R2/R3", "per-cycle outputs", actV, expV);
    end
  end

  task automatic setCfg(input int cs, input int s, input int p, input int h, input int fl, input bit o);
    cfgWe = 1'b1; cfgSel = cs; cfgSetup = s; cfgPulse = p; cfgHold = h; cfgFloat = fl; cfgOpt = o;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Called at a negedge; returns at the negedge of the first idle cycle after the access.
  task automatic doAccess(input int cs, input bit wr, output int nWait, output int nPulse);
    reqValid = 1'b1; reqCs = cs; reqWrite = wr;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    nWait = 0; nPulse = 0;
    while (!reqReady) begin
      if (waitState) nWait++;
      if (rdStrobe || wrStrobe) nPulse++;
      @(negedge clk);
    end
  endtask

  task automatic acc(input string tag, input int cs, input bit wr, input int expW);
    int nw, np;
    doAccess(cs, wr, nw, np);
    chk(tag, $sformatf("inserted waits cs%0d %s", cs, wr ? "write" : "read"), nw, expW);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int nw, np;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8", "reqReady", reqReady, 1);
    chk("R8", "phases", {waitState, setupPhase, rdStrobe, wrStrobe, holdPhase}, 0);
    chk("R8", "csActive", csActive, 0);
    chk("R8", "floatBusy", floatBusy, 0);
    // R8: zero timing set -> one strobe cycle, no waits, no float
    doAccess(2, 1'b0, nw, np);
    chk("R8", "default strobe length", np, 1);
    chk("R8", "default waits", nw, 0);
    repeat (4) @(negedge clk);

    setCfg(0, 3, 1, 4, 6, 1'b1);
    setCfg(1, 3, 1, 4, 9, 1'b0);
    setCfg(2, 3, 1, 4, 9, 1'b1);
    setCfg(3, 0, 0, 0, 3, 1'b0);
    repeat (12) @(negedge clk);

    acc("R7", 0, 1'b0, 0);   // no float outstanding
    acc("R6", 0, 1'b1, 1);   // overlapped float absorbed, turnaround remains
    acc("R3", 1, 1'b0, 0);   // write did not start a float
    acc("R4", 0, 1'b0, 4);   // plain read->read other select
    acc("R6", 1, 1'b1, 1);   // overlapped absorbed, read->write turnaround
    acc("R3", 2, 1'b0, 0);
    acc("R5", 0, 1'b0, 1);   // overlapped: 4 remaining - setup 3
    acc("R5", 1, 1'b0, 0);   // overlapped fully absorbed
    acc("R5", 2, 1'b0, 4);   // mode from reading select (plain) not next (overlapped)
    acc("R5", 3, 1'b1, 4);   // overlapped with zero next setup
    acc("R3", 3, 1'b0, 0);
    acc("R4", 3, 1'b0, 2);   // zero hold: idle cycle only
    acc("R4", 1, 1'b1, 2);   // plain read->write same-size float beats turnaround
    acc("R3", 1, 1'b0, 0);
    repeat (12) @(negedge clk);
    acc("R7", 0, 1'b0, 0);   // float expired while idle
    repeat (12) @(negedge clk);
    acc("R6", 2, 1'b1, 1);   // turnaround kept across idle

    setCfg(0, 3, 1, 4, 0, 1'b1);
    fork
      begin
        doAccess(1, 1'b0, nw, np);
        chk("R1", "strobe length with mid-access rewrite", np, 2);
        chk("R1", "waits with mid-access rewrite", nw, 0);
      end
      begin
        repeat (3) @(negedge clk);
        setCfg(1, 3, 4, 4, 9, 1'b0);
      end
    join
    doAccess(1, 1'b0, nw, np);
    chk("R1", "strobe length after rewrite", np, 5);
    chk("R4", "waits after longer strobe", nw, 4);
    acc("R4", 0, 1'b0, 4);
    acc("R3", 0, 1'b0, 0);   // float length zero
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule